// File: doc/BRIEF.md
# Interleaved Block Placement Sequencer

This block sequences the placement of logical partition tasks onto the physical processing elements of a square array while successive data blocks are processed. Each logical position is numbered row-major (position = row * COLS + column). For each block the sequencer presents, in parallel, the physical element that hosts every logical position. Between blocks it reflects the placement along the row axis, the column axis or both. The results of one block therefore land next to the elements that consume them in the next block, and only neighbour links are needed.

A start pulse arms the sequencer and places the first block with the identity mapping. Each later next-block pulse advances through a four-step cycle of reflections, and the cycle wraps around. Every accepted pulse produces a one-cycle reconfigure strobe. The strobe appears in the same cycle as the new mapping and the new mode code, and it tells the link fabric to reconfigure before the block runs.

Top module: `blkmap_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, mode_o is 0, reconf_o is 0, and every field of map_o equals its own position (identity).
- R2: Before the first start pulse after reset, next_i is ignored: reconf_o stays 0 and map_o and mode_o keep their reset values.
- R3: A start pulse (start_i high at a rising edge) sets mode 0 and the identity mapping. This also applies when the sequence is already running, and the sequence then restarts from step 0.
- R4: After start, each next_i pulse advances the step 0→1→2→3→0. mode_o equals the step: bit 0 set means row order reversed, and bit 1 set means column order reversed.
- R5: Field p of map_o (bits p*IDX_W upward, with p = r*COLS + c) holds r'*COLS + c'. Here r' is ROWS-1-r when mode bit 0 is set and r otherwise, and c' is COLS-1-c when mode bit 1 is set and c otherwise.
- R6: reconf_o is high for exactly the one cycle that follows each accepted pulse, and consecutive pulses give consecutive strobes. map_o and mode_o update in that same cycle and do not change in any cycle where reconf_o is 0.
- R7: When start_i and next_i are high at the same edge, start takes priority. The result is mode 0 with the identity mapping, and the step does not advance.
- R8: map_o is always a permutation of 0..ROWS*COLS-1 in which each field points back to its own position (the mapping is its own inverse).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse: arm and place the first block |
| next_i | input | 1 | Next-block pulse: advance the reflection step |
| map_o | output | ROWS*COLS*IDX_W (36) | Physical element index for each logical position, position 0 in the low field |
| reconf_o | output | 1 | One-cycle link reconfigure strobe |
| mode_o | output | 2 | Reflection code: bit 0 rows reversed, bit 1 columns reversed |

## Verification
Several situations can only be reached through a specific history of pulses. The wrap from step 3 back to 0 needs four accepted pulses after a start. A restart needs a start arriving in the middle of the sequence. The priority case needs start and next in the same cycle. The bench reaches them with a long series of next pulses separated by varied idle gaps, then back-to-back pulses, a mid-run restart and a coincident start/next pair. After every block it checks all nine fields against a mapping computed arithmetically.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;

  // Reflection code carried on mode_o: bit 0 reverses rows, bit 1 columns.
  typedef enum logic [1:0] {
    MIR_NONE = 2'd0,
    MIR_ROW  = 2'd1,
    MIR_COL  = 2'd2,
    MIR_BOTH = 2'd3
  } mirror_mode_t;

  // Physical home of a logical position under a given reflection.
  function automatic int mirror_pos(input int pos, input int rows, input int cols,
                                    input logic row_rev, input logic col_rev);
    int r;
    int c;
    int pr;
    int pc;
    r  = pos / cols;
    c  = pos % cols;
    pr = row_rev ? (rows - 1 - r) : r;
    pc = col_rev ? (cols - 1 - c) : c;
    return pr * cols + pc;
  endfunction

  // Step index to reflection code; the cycle order is fixed here.
  function automatic mirror_mode_t step_mode(input logic [1:0] step);
    case (step)
      2'd0:    return MIR_NONE;
      2'd1:    return MIR_ROW;
      2'd2:    return MIR_COL;
      default: return MIR_BOTH;
    endcase
  endfunction

endpackage

// File: rtl/blkmap_step_ctrl.sv
module blkmap_step_ctrl
  import blkmap_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         next_i,
  output logic         run_o,
  output logic         load_o,
  output mirror_mode_t mode_next_o,
  output mirror_mode_t mode_o,
  output logic         strobe_o,
  output logic         accept_start_o,
  output logic         accept_next_o
);

  logic [1:0] step_q;
  logic [1:0] step_d;
  logic       run_q;
  logic       strobe_q;

  // Start wins over next; next only counts once armed.
  assign accept_start_o = start_i;
  assign accept_next_o  = run_q && next_i && !start_i;
  assign load_o         = accept_start_o || accept_next_o;

  always_comb begin
    if (accept_start_o) step_d = 2'd0;
    else                step_d = step_q + 2'd1;
  end

  assign mode_next_o = step_mode(step_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      step_q   <= 2'd0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= load_o;
      if (accept_start_o) run_q <= 1'b1;
      if (load_o)         step_q <= step_d;
    end
  end

  assign run_o    = run_q;
  assign mode_o   = step_mode(step_q);
  assign strobe_o = strobe_q;

endmodule

// File: rtl/blkmap_cell.sv
module blkmap_cell
  import blkmap_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int COLS  = 3,
  parameter int POS   = 0,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  mirror_mode_t     mode_i,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] HOME = IDX_W'(POS);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  assign idx_d = IDX_W'(mirror_pos(POS, ROWS, COLS, mode_i[0], mode_i[1]));

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= HOME;
    else if (load_i) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/blkmap_seq.sv
module blkmap_seq
  import blkmap_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  localparam int NPOS  = ROWS * COLS,
  localparam int IDX_W = (NPOS > 1) ? $clog2(NPOS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  next_i,
  output logic [NPOS*IDX_W-1:0] map_o,
  output logic                  reconf_o,
  output logic [1:0]            mode_o
);

  logic         run_w;
  logic         load_w;
  logic         accept_start_w;
  logic         accept_next_w;
  mirror_mode_t mode_next_w;
  mirror_mode_t mode_w;
  logic         strobe_w;

  blkmap_step_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .next_i         (next_i),
    .run_o          (run_w),
    .load_o         (load_w),
    .mode_next_o    (mode_next_w),
    .mode_o         (mode_w),
    .strobe_o       (strobe_w),
    .accept_start_o (accept_start_w),
    .accept_next_o  (accept_next_w)
  );

  for (genvar p = 0; p < NPOS; p++) begin : g_cell
    blkmap_cell #(
      .ROWS  (ROWS),
      .COLS  (COLS),
      .POS   (p),
      .IDX_W (IDX_W)
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_w),
      .mode_i (mode_next_w),
      .idx_o  (map_o[p*IDX_W +: IDX_W])
    );
  end

  assign reconf_o = strobe_w;
  assign mode_o   = mode_w;

endmodule

// File: rtl/blkmap_seq_chk.sv
module blkmap_seq_chk #(
  parameter int ROWS  = 3,
  parameter int COLS  = 3,
  parameter int IDX_W = 4,
  localparam int NPOS = ROWS * COLS
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  next_i,
  input logic                  run_w,
  input logic                  accept_start_w,
  input logic [NPOS*IDX_W-1:0] map_o,
  input logic                  reconf_o,
  input logic [1:0]            mode_o
);

  logic self_inverse;
  logic [IDX_W-1:0] corner_exp;

  always_comb begin
    self_inverse = 1'b1;
    for (int p = 0; p < NPOS; p++) begin
      logic [IDX_W-1:0] tgt;
      tgt = map_o[p*IDX_W +: IDX_W];
      if (int'(tgt) >= NPOS) self_inverse = 1'b0;
      else if (map_o[int'(tgt)*IDX_W +: IDX_W] != IDX_W'(p)) self_inverse = 1'b0;
    end
  end

  always_comb begin
    case (mode_o)
      2'd0:    corner_exp = '0;
      2'd1:    corner_exp = IDX_W'((ROWS - 1) * COLS);
      2'd2:    corner_exp = IDX_W'(COLS - 1);
      default: corner_exp = IDX_W'(NPOS - 1);
    endcase
  end

  // R3
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start_w |=> (reconf_o && mode_o == 2'd0));

  // R4
  mode_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && next_i && !start_i) |=> (mode_o == $past(mode_o) + 2'd1));

  // R2
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_w && !start_i) |=> !reconf_o);

  // R6
  no_extra_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i || (run_w && next_i)) |=> !reconf_o);

  // R6
  hold_mapping_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reconf_o |-> ($stable(map_o) && $stable(mode_o)));

  // R8
  self_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_inverse);

  // R5
  corner_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_o[IDX_W-1:0] == corner_exp);

endmodule

bind blkmap_seq blkmap_seq_chk #(
  .ROWS  (ROWS),
  .COLS  (COLS),
  .IDX_W (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .next_i         (next_i),
  .run_w          (run_w),
  .accept_start_w (accept_start_w),
  .map_o          (map_o),
  .reconf_o       (reconf_o),
  .mode_o         (mode_o)
);

// File: tb/blkmap_seq_test.sv
module blkmap_seq_test;

  localparam int ROWS = 3;
  localparam int COLS = 3;
  localparam int NPOS = ROWS * COLS;
  localparam int W    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic next_i = 1'b0;
  logic [NPOS*W-1:0] map_o;
  logic reconf_o;
  logic [1:0] mode_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  blkmap_seq #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .next_i   (next_i),
    .map_o    (map_o),
    .reconf_o (reconf_o),
    .mode_o   (mode_o)
  );

  // Expected home: offset the position by the mirrored distance.
  function automatic int want_idx(input int p, input int m);
    int r = p / COLS;
    int c = p % COLS;
    int v = p;
    if (m % 2 == 1) v = v + (ROWS - 1 - 2 * r) * COLS;
    if (m / 2 == 1) v = v + (COLS - 1 - 2 * c);
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Whole-table check against mode m, plus permutation test.
  task automatic check_map(input string tag, input int m);
    int bad = 0;
    int first_act = 0;
    int first_exp = 0;
    bit [NPOS-1:0] seen = '0;
    for (int p = 0; p < NPOS; p++) begin
      int a = int'(map_o[p*W +: W]);
      if (a != want_idx(p, m) && bad == 0) begin
        first_act = a * 100 + p;
        first_exp = want_idx(p, m) * 100 + p;
      end
      if (a != want_idx(p, m)) bad++;
      if (a < NPOS) seen[a] = 1'b1;
    end
    check({tag, " map(field*100+pos)"}, first_act, first_exp);
    check("R8 permutation", int'(&seen), 1);
  endtask

  task automatic pulse(input logic s, input logic n);
    @(negedge clk);
    start_i = s;
    next_i  = n;
    @(negedge clk);
    start_i = 1'b0;
    next_i  = 1'b0;
  endtask

  initial begin
    int exp_mode;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 reconf in reset", int'(reconf_o), 0);
    check("R1 mode in reset", int'(mode_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reconf after reset", int'(reconf_o), 0);
    check_map("R1", 0);

    // R2: next before start does nothing
    for (int k = 0; k < 3; k++) begin
      pulse(1'b0, 1'b1);
      check("R2 no strobe when idle", int'(reconf_o), 0);
      check("R2 mode held when idle", int'(mode_o), 0);
      check_map("R2", 0);
    end

    // R3: start
    pulse(1'b1, 1'b0);
    check("R3 strobe on start", int'(reconf_o), 1);
    check("R3 mode on start", int'(mode_o), 0);
    check_map("R3", 0);
    @(negedge clk);
    check("R6 strobe one cycle", int'(reconf_o), 0);

    // R4/R5/R6: sweep with varied idle gaps, wraps three times
    exp_mode = 0;
    for (int b = 0; b < 12; b++) begin
      pulse(1'b0, 1'b1);
      exp_mode = (exp_mode + 1) % 4;
      check("R6 strobe after next", int'(reconf_o), 1);
      check("R4 mode step", int'(mode_o), exp_mode);
      check_map("R5", exp_mode);
      for (int g = 0; g <= b % 3; g++) begin
        @(negedge clk);
        check("R6 strobe low in gap", int'(reconf_o), 0);
        check("R6 mode stable in gap", int'(mode_o), exp_mode);
      end
      check_map("R6 gap", exp_mode);
    end

    // R6: back-to-back pulses give back-to-back strobes
    @(negedge clk);
    next_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      exp_mode = (exp_mode + 1) % 4;
      check("R6 consecutive strobe", int'(reconf_o), 1);
      check("R4 consecutive mode", int'(mode_o), exp_mode);
      check_map("R5 consecutive", exp_mode);
    end
    next_i = 1'b0;
    @(negedge clk);
    check("R6 strobe ends", int'(reconf_o), 0);

    // Bring to a non-zero step, then restart (R3)
    while (exp_mode != 2) begin
      pulse(1'b0, 1'b1);
      exp_mode = (exp_mode + 1) % 4;
    end
    check("R4 setup mode 2", int'(mode_o), 2);
    pulse(1'b1, 1'b0);
    check("R3 restart strobe", int'(reconf_o), 1);
    check("R3 restart mode", int'(mode_o), 0);
    check_map("R3 restart", 0);
    pulse(1'b0, 1'b1);
    check("R3 resumes at step 1", int'(mode_o), 1);

    // R7: start and next together
    pulse(1'b0, 1'b1);
    check("R7 setup mode 2", int'(mode_o), 2);
    pulse(1'b1, 1'b1);
    check("R7 strobe", int'(reconf_o), 1);
    check("R7 start wins", int'(mode_o), 0);
    check_map("R7", 0);
    pulse(1'b0, 1'b1);
    check("R7 next after coincident", int'(mode_o), 1);
    check_map("R5 after R7", 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule